// File: doc/BRIEF.md
# Boot Source Select Status Register

This block records where the processor should boot from and exposes that choice as one read-only 32-bit word on an APB slave port. Each time cold reset is released, it samples the three boot-strap pins on the board and holds that value until the next cold reset. A warm reset does not disturb it. The programmable fabric can also supply its own 3-bit boot choice and an enable. The fabric's enable only counts once the fabric reports that its configuration is complete. Until then, the pin value wins.

The fabric-side inputs pass through a two-flop synchronizer before they are used. The status word carries four things: the chosen boot source, the latched pins, the synchronized fabric choice and the effective fabric enable. Boot source codes are: 0 reserved, 1 fabric, 2 NAND at 1.8 V, 3 NAND at 3.0 V, 4 SD/MMC with external transceiver at 1.8 V, 5 SD/MMC with internal transceiver at 3.0 V, 6 QSPI at 1.8 V, 7 QSPI at 3.0 V. Any write is refused with a slave error. Reads at addresses other than the register's own return zero, so the enclosing block can do the wider decode.

Top module: `boot_src_status`

## Requirements
- R1: On the first rising clock edge after `cold_rst_n` goes high, `strap_sel` is captured. The captured value then stays fixed, whatever the pins do, until `cold_rst_n` is next asserted.
- R2: Holding `warm_rst_n` low changes no field of the status word.
- R3: The effective fabric enable, in bit 0, is the synchronized `fab_sel_en` ANDed with the synchronized `fab_cfg_done`. It reads 0 whenever configuration is not complete.
- R4: Bits 14:12 carry the chosen boot source. They equal the synchronized `fab_sel` when bit 0 is 1, and the captured pins when bit 0 is 0.
- R5: Bits 10:8 carry the captured pins and bits 6:4 carry the synchronized `fab_sel`. Bits 31:15, 11, 7 and 3:1 always read 0.
- R6: Any write access (`psel`, `penable` and `pwrite` all high) completes with `pslverr`=1 and `prdata`=0, and changes no field.
- R7: A read completes with no wait states (`pready`=1) and `pslverr`=0. It returns the status word at byte address 0xC, and 0 at every other address.
- R8: While `cold_rst_n` is low, every field reads 0.
- R9: A change on the fabric inputs becomes visible in the word after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low; release triggers pin capture |
| warm_rst_n | input | 1 | Warm reset, active low; leaves the register untouched |
| strap_sel | input | 3 | Board boot-strap pins |
| fab_sel | input | 3 | Boot source chosen by the fabric (asynchronous) |
| fab_sel_en | input | 1 | Fabric request to use `fab_sel` (asynchronous) |
| fab_cfg_done | input | 1 | Fabric configuration complete (asynchronous) |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W (12) | APB byte address |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, high on writes |

## Verification
The assertions check four properties on every cycle:
- the captured pins hold steady, through warm reset as well;
- the chosen source follows the fabric only when bit 0 is set, and follows the pins whenever configuration is incomplete;
- reserved bits are zero on every read;
- every write returns an error with zero data.

Some behaviour only the bench's scenarios can show: that the pins seen at the release edge are the ones kept, that a second cold reset takes a fresh sample, and the exact two-edge latency of the fabric synchronizer. The scenarios also walk configuration-complete down and back up to confirm the fallback to the pins.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam int SEL_W   = 3;
  localparam int WORD_W  = 32;
  localparam int MUX_LSB = 12;
  localparam int PIN_LSB = 8;
  localparam int FAB_LSB = 4;
  localparam int EN_BIT  = 0;

  localparam logic [WORD_W-1:0] FIELD_MASK =
      (WORD_W'(7) << MUX_LSB) | (WORD_W'(7) << PIN_LSB) |
      (WORD_W'(7) << FAB_LSB) | (WORD_W'(1) << EN_BIT);

  // selection between fabric choice and latched straps
  function automatic logic [SEL_W-1:0] pick_src(input logic use_fab,
                                                input logic [SEL_W-1:0] fab,
                                                input logic [SEL_W-1:0] pins);
    return use_fab ? fab : pins;
  endfunction

  // place the four fields into the status word
  function automatic logic [WORD_W-1:0] pack_status(input logic [SEL_W-1:0] chosen,
                                                    input logic [SEL_W-1:0] pins,
                                                    input logic [SEL_W-1:0] fab,
                                                    input logic use_fab);
    logic [WORD_W-1:0] w;
    w = '0;
    w[MUX_LSB +: SEL_W] = chosen;
    w[PIN_LSB +: SEL_W] = pins;
    w[FAB_LSB +: SEL_W] = fab;
    w[EN_BIT]           = use_fab;
    return w;
  endfunction
endpackage

// File: rtl/bsel_sync.sv
module bsel_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bsel_strap_latch.sv
module bsel_strap_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] pins_q,
  output logic         armed_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      armed_q <= 1'b0;
      pins_q  <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      pins_q  <= strap_i;
    end
  end

  assign armed_o = armed_q;

  // R1
  strap_capture_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $rose(armed_q) |-> pins_q == $past(strap_i));

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    armed_q |=> $stable(pins_q));
endmodule

// File: rtl/bsel_apb_ro.sv
module bsel_apb_ro #(
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'hC
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       status_i,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr
);
  logic access;
  logic hit;

  assign access  = psel & penable;
  assign hit     = (paddr == REG_OFS);
  assign pready  = 1'b1;
  assign pslverr = access & pwrite;
  assign prdata  = (access && !pwrite && hit) ? status_i : '0;
endmodule

// File: rtl/boot_src_status.sv
module boot_src_status
  import boot_sel_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_OFS     = 'hC,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic [2:0]        strap_sel,
  input  logic [2:0]        fab_sel,
  input  logic              fab_sel_en,
  input  logic              fab_cfg_done,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr
);
  localparam int FAB_W = SEL_W + 2;

  logic [SEL_W-1:0]  pins_q;
  logic              armed;
  logic [FAB_W-1:0]  fab_raw, fab_s;
  logic [SEL_W-1:0]  fsel_s;
  logic              fen_s, cfg_s;
  logic              eff_en;
  logic [SEL_W-1:0]  chosen;
  logic [WORD_W-1:0] status_word;

  // named events for the assertions
  logic rd_hit, wr_acc, rd_acc;

  bsel_strap_latch #(.W(SEL_W)) u_latch (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .strap_i    (strap_sel),
    .pins_q     (pins_q),
    .armed_o    (armed)
  );

  assign fab_raw = {fab_cfg_done, fab_sel_en, fab_sel};

  bsel_sync #(.W(FAB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (cold_rst_n),
    .d     (fab_raw),
    .q     (fab_s)
  );

  assign fsel_s      = fab_s[SEL_W-1:0];
  assign fen_s       = fab_s[SEL_W];
  assign cfg_s       = fab_s[SEL_W+1];
  assign eff_en      = fen_s & cfg_s;
  assign chosen      = pick_src(eff_en, fsel_s, pins_q);
  assign status_word = pack_status(chosen, pins_q, fsel_s, eff_en);

  bsel_apb_ro #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_apb (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .status_i (status_word),
    .prdata   (prdata),
    .pready   (pready),
    .pslverr  (pslverr)
  );

  assign rd_acc = psel & penable & ~pwrite;
  assign wr_acc = psel & penable & pwrite;
  assign rd_hit = rd_acc & (paddr == REG_OFS);

  // R2
  warm_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst_n && armed) |=> $stable(pins_q));

  // R3
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rd_hit && !cfg_s) |-> (prdata[EN_BIT] == 1'b0 &&
                            prdata[MUX_LSB +: SEL_W] == pins_q));

  // R4
  fab_pick_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rd_hit && prdata[EN_BIT]) |-> prdata[MUX_LSB +: SEL_W] == prdata[FAB_LSB +: SEL_W]);

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rd_acc |-> (prdata & ~FIELD_MASK) == '0);

  // R6
  write_err_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    wr_acc |-> (pslverr && prdata == '0));

  // R7
  read_ok_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rd_acc |-> (!pslverr && pready));
endmodule

// File: tb/boot_src_status_tb_top.sv
module boot_src_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        cold_rst_n, warm_rst_n;
  logic [2:0]  strap_sel, fab_sel;
  logic        fab_sel_en, fab_cfg_done;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] prdata;
  logic        pready, pslverr;

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_src_status dut_i (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .strap_sel(strap_sel), .fab_sel(fab_sel), .fab_sel_en(fab_sel_en),
    .fab_cfg_done(fab_cfg_done), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .pready(pready),
    .pslverr(pslverr)
  );

  // independent model of the status word
  function automatic logic [31:0] model(input logic [2:0] p, input logic [2:0] f,
                                        input logic en, input logic cfg);
    logic       u;
    logic [2:0] m;
    u = en & cfg;
    m = u ? f : p;
    return {17'd0, m, 1'b0, p, 1'b0, f, 3'd0, u};
  endfunction

  // monitor: compare each access phase against the scoreboard
  always @(negedge clk) begin
    exp_t x;
    if (psel && penable) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R7: access with no expectation, prdata=%h expected none", prdata);
      end else begin
        x = sb.pop_front();
        if (prdata !== x.d || pslverr !== x.e || pready !== 1'b1) begin
          bad++;
          $display("FAIL %s: prdata=%h err=%b rdy=%b expected prdata=%h err=%b rdy=1",
                   x.tag, prdata, pslverr, pready, x.d, x.e);
        end
      end
    end
  end

  // driver: called at posedge+1, pushes expectation then runs the transfer
  task automatic xfer(input logic [11:0] a, input logic wr, input logic [31:0] ed,
                      input logic ee, input string tag);
    sb.push_back('{d: ed, e: ee, tag: tag});
    paddr = a; pwrite = wr; psel = 1'b1; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    cold_rst_n = 1'b0; warm_rst_n = 1'b1;
    strap_sel = 3'd6; fab_sel = 3'd0; fab_sel_en = 1'b0; fab_cfg_done = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
    step(2);

    // R8: all zero during cold reset
    xfer(12'hC, 1'b0, 32'd0, 1'b0, "R8");

    // R1: capture on release
    cold_rst_n = 1'b1;
    step(1);
    strap_sel = 3'd2;
    step(2);
    xfer(12'hC, 1'b0, model(3'd6, 3'd0, 1'b0, 1'b0), 1'b0, "R1");

    // R9: one edge is not enough; R3: enable gated by cfg
    fab_sel = 3'd3; fab_sel_en = 1'b1;
    xfer(12'hC, 1'b0, model(3'd6, 3'd0, 1'b0, 1'b0), 1'b0, "R9");
    xfer(12'hC, 1'b0, model(3'd6, 3'd3, 1'b1, 1'b0), 1'b0, "R3");

    // R9 then R4: fabric wins once cfg done
    fab_cfg_done = 1'b1;
    xfer(12'hC, 1'b0, model(3'd6, 3'd3, 1'b1, 1'b0), 1'b0, "R9");
    xfer(12'hC, 1'b0, model(3'd6, 3'd3, 1'b1, 1'b1), 1'b0, "R4");

    fab_sel = 3'd5;
    step(2);
    xfer(12'hC, 1'b0, model(3'd6, 3'd5, 1'b1, 1'b1), 1'b0, "R4");

    // R3: cfg drop falls back to pins
    fab_cfg_done = 1'b0;
    step(2);
    xfer(12'hC, 1'b0, model(3'd6, 3'd5, 1'b1, 1'b0), 1'b0, "R3");
    fab_cfg_done = 1'b1;
    step(2);

    // R2: warm reset keeps everything
    warm_rst_n = 1'b0; strap_sel = 3'd7;
    step(3);
    xfer(12'hC, 1'b0, model(3'd6, 3'd5, 1'b1, 1'b1), 1'b0, "R2");
    warm_rst_n = 1'b1;
    step(1);
    xfer(12'hC, 1'b0, model(3'd6, 3'd5, 1'b1, 1'b1), 1'b0, "R2");

    // R6: writes error and change nothing
    xfer(12'hC, 1'b1, 32'd0, 1'b1, "R6");
    xfer(12'h8, 1'b1, 32'd0, 1'b1, "R6");
    xfer(12'hC, 1'b0, model(3'd6, 3'd5, 1'b1, 1'b1), 1'b0, "R6");

    // R7: other addresses read zero without error
    xfer(12'h8,   1'b0, 32'd0, 1'b0, "R7");
    xfer(12'hD,   1'b0, 32'd0, 1'b0, "R7");
    xfer(12'h10C, 1'b0, 32'd0, 1'b0, "R7");

    // R5/R3: enable low leaves fields in place
    fab_sel_en = 1'b0;
    step(2);
    xfer(12'hC, 1'b0, model(3'd6, 3'd5, 1'b0, 1'b1), 1'b0, "R5");

    // R8 and R1: second cold reset takes a fresh sample
    cold_rst_n = 1'b0; strap_sel = 3'd5;
    step(1);
    xfer(12'hC, 1'b0, 32'd0, 1'b0, "R8");
    cold_rst_n = 1'b1;
    step(1);
    strap_sel = 3'd1;
    step(2);
    xfer(12'hC, 1'b0, model(3'd5, 3'd5, 1'b0, 1'b1), 1'b0, "R1");

    step(2);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R7: %0d expectations left, expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule